// File: doc/BRIEF.md
# Mixed-Sign Fractional Multiply Unit

This unit is the multiply datapath of a 16-bit signal-processing core. Its first operand is a signed two's-complement value and its second an unsigned value, so the order of the operands matters. The unit forms the fractional product, which is the integer product doubled by a one-bit left shift. It sign-extends that product into a 36-bit accumulator image: a 4-bit extension field above two 16-bit words. It also presents the upper 16-bit word for instructions that write a 16-bit register.

The unit passes the product straight through with no saturation or limiting. A 16-bit destination therefore receives a plain truncation and can lose the sign of large products. Alongside each result the unit delivers six condition flags, evaluated for whichever destination the request names.

A request is one cycle of `in_valid` with both operands and the destination select. The result appears on the outputs with a one-cycle `out_valid` pulse a fixed latency later. An optional input register stage is chosen by parameter.

Top module: `mixmul_unit`

## Requirements
- R1: The accumulator output is the 36-bit two's-complement value 2 × S1 × S2, where S1 is `in_s1` read as signed and S2 is `in_s2` read as unsigned. The product is sign-extended through bits 35:32.
- R2: S1 = 0xFFF4 with S2 = 0x0002 yields an accumulator value of 0xF_FFFF_FFD0.
- R3: `out_word` is always bits 31:16 of the accumulator value, with no clamping. For example, S1 = 0x8000 with S2 = 0xFFFF gives accumulator 0xF_0001_0000 and word 0x0001.
- R4: `out_valid` rises exactly 1 + IN_REG cycles after a cycle with `in_valid` high, for one cycle per request. Requests may arrive on every cycle.
- R5: In a cycle where no result is delivered, `out_acc`, `out_word` and `out_flags` keep the last delivered values.
- R6: The flag bits are: bit 5 limit (L), bit 4 extension in use (E), bit 3 unnormalized (U), bit 2 negative (N), bit 1 zero (Z), bit 0 overflow (V). With `in_dst` = 0 (accumulator), N is accumulator bit 35 and Z is set when all 36 bits are zero.
- R7: With `in_dst` = 0, E is set when bits 35:31 are not all equal. V and L are 0.
- R8: In both modes, U is set when accumulator bits 31 and 30 are equal.
- R9: With `in_dst` = 1 (16-bit register), N is word bit 15, Z is set when the word is zero, and E is 0. V and L are both set when accumulator bits 35:31 are not all equal, which is exactly when the word's sign differs from the true product's sign.
- R10: While reset is high and on the first cycle after it, `out_valid` is 0 and `out_acc`, `out_word` and `out_flags` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_s1 | input | OP_W | Signed multiplicand |
| in_s2 | input | OP_W | Unsigned multiplier |
| in_dst | input | 1 | Destination select: 0 accumulator, 1 16-bit register |
| out_valid | output | 1 | Result strobe |
| out_acc | output | EXT_W+2·OP_W | Sign-extended fractional product |
| out_word | output | OP_W | Upper product word (bits 31:16) |
| out_flags | output | 6 | Condition flags L,E,U,N,Z,V (bit 5 down to 0) |

## Verification
The assertions assume that the product of a signed and an unsigned 16-bit operand never needs more than 33 bits. Every accumulator bit above bit 32 is therefore a copy of the sign, and the sign-loss and sign-of-product checks rely on this. They also assume that `in_s1`, `in_s2` and `in_dst` are driven to known values whenever `in_valid` is high.

The stimulus meets these assumptions in three ways. It drives every input on the falling edge and holds `in_valid` low through reset. It mixes the directed extremes 0x0000, 0x8000, 0x7FFF and 0xFFFF with seeded random operands and random gaps between requests.

// File: rtl/mixmul_pkg.sv
`timescale 1ns/1ps
package mixmul_pkg;

    // Default operand and extension widths
    localparam int unsigned MM_OP_W  = 16;
    localparam int unsigned MM_EXT_W = 4;

    // Destination of the product
    typedef enum logic {
        DST_ACC  = 1'b0,
        DST_WORD = 1'b1
    } dst_e;

    // Condition flags, most significant first
    typedef struct packed {
        logic lim;
        logic ext;
        logic unn;
        logic neg;
        logic zero;
        logic ovf;
    } ccr_t;

    localparam int unsigned CCR_W = $bits(ccr_t);

    // True when every bit of a 5-bit top slice is equal
    function automatic logic slice_uniform(input logic [4:0] s);
        return (&s) | ~(|s);
    endfunction

endpackage

// File: rtl/mixmul_stage.sv
`timescale 1ns/1ps
module mixmul_stage #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         vin,
    input  logic [W-1:0] din,
    output logic         vout,
    output logic [W-1:0] dout
);

    always_ff @(posedge clk) begin
        if (rst) begin
            vout <= 1'b0;
            dout <= '0;
        end else begin
            vout <= vin;
            if (vin) begin
                dout <= din;
            end
        end
    end

    // R4
    valid_pipe_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> vout == $past(vin));

    // R5
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !vin |=> $stable(dout));

endmodule

// File: rtl/mixmul_core.sv
`timescale 1ns/1ps
module mixmul_core #(
    parameter int unsigned OP_W  = 16,
    parameter int unsigned EXT_W = 4,
    localparam int unsigned ACC_W = EXT_W + 2*OP_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [OP_W-1:0]  s1,
    input  logic [OP_W-1:0]  s2,
    output logic [ACC_W-1:0] acc
);

    localparam int unsigned PW = 2*OP_W + 2;

    logic signed [OP_W:0]    a_ext;
    logic signed [OP_W:0]    b_ext;
    logic signed [PW-1:0]    prod;
    logic signed [ACC_W-1:0] prod_wide;

    // signed operand: copy the sign; unsigned operand: prepend zero
    assign a_ext     = {s1[OP_W-1], s1};
    assign b_ext     = {1'b0, s2};
    assign prod      = a_ext * b_ext;
    assign prod_wide = ACC_W'(prod);
    assign acc       = {prod_wide[ACC_W-2:0], 1'b0};

    // R1: product is negative exactly when s1 is negative and s2 is nonzero
    sign_of_product_chk: assert property (@(posedge clk) disable iff (rst)
        acc[ACC_W-1] == (s1[OP_W-1] && (s2 != '0)));

endmodule

// File: rtl/mixmul_flags.sv
`timescale 1ns/1ps
module mixmul_flags
    import mixmul_pkg::*;
#(
    parameter int unsigned OP_W  = 16,
    parameter int unsigned EXT_W = 4,
    localparam int unsigned ACC_W = EXT_W + 2*OP_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ACC_W-1:0] acc,
    input  dst_e             dst,
    output logic [OP_W-1:0]  word,
    output ccr_t             flags
);

    localparam int unsigned TOPB = 2*OP_W - 1;

    logic [4:0] top_slice;
    logic       ext_used;
    logic       unnorm;

    assign word      = acc[TOPB -: OP_W];
    assign top_slice = acc[ACC_W-1 -: 5];
    assign ext_used  = ~slice_uniform(top_slice);
    assign unnorm    = (acc[TOPB] == acc[TOPB-1]);

    always_comb begin
        flags     = '0;
        flags.unn = unnorm;
        if (dst == DST_WORD) begin
            flags.neg  = word[OP_W-1];
            flags.zero = (word == '0);
            flags.ovf  = ext_used;
            flags.lim  = ext_used;
        end else begin
            flags.neg  = acc[ACC_W-1];
            flags.zero = (acc == '0);
            flags.ext  = ext_used;
        end
    end

    // R9: an overflow on a word destination means the stored sign is wrong
    sign_loss_chk: assert property (@(posedge clk) disable iff (rst)
        (dst == DST_WORD && flags.ovf) |-> (word[OP_W-1] != acc[ACC_W-1]));

endmodule

// File: rtl/mixmul_unit.sv
`timescale 1ns/1ps
module mixmul_unit
    import mixmul_pkg::*;
#(
    parameter int unsigned OP_W   = MM_OP_W,
    parameter int unsigned EXT_W  = MM_EXT_W,
    parameter int unsigned IN_REG = 1,
    localparam int unsigned ACC_W = EXT_W + 2*OP_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [OP_W-1:0]  in_s1,
    input  logic [OP_W-1:0]  in_s2,
    input  logic             in_dst,
    output logic             out_valid,
    output logic [ACC_W-1:0] out_acc,
    output logic [OP_W-1:0]  out_word,
    output logic [CCR_W-1:0] out_flags
);

    localparam int unsigned IN_W  = 2*OP_W + 1;
    localparam int unsigned OUT_W = ACC_W + OP_W + CCR_W;

    logic [IN_W-1:0]  req_d;
    logic [IN_W-1:0]  req_q;
    logic             req_v;
    logic [OP_W-1:0]  s1_q;
    logic [OP_W-1:0]  s2_q;
    dst_e             dst_q;
    logic [ACC_W-1:0] acc_c;
    logic [OP_W-1:0]  word_c;
    ccr_t             flags_c;
    logic [OUT_W-1:0] res_d;
    logic [OUT_W-1:0] res_q;

    assign req_d = {in_dst, in_s1, in_s2};

    generate
        if (IN_REG != 0) begin : g_in_reg
            mixmul_stage #(.W(IN_W)) u_in_stage (
                .clk (clk),
                .rst (rst),
                .vin (in_valid),
                .din (req_d),
                .vout(req_v),
                .dout(req_q)
            );
        end else begin : g_in_pass
            assign req_v = in_valid;
            assign req_q = req_d;
        end
    endgenerate

    assign dst_q = dst_e'(req_q[IN_W-1]);
    assign s1_q  = req_q[2*OP_W-1 -: OP_W];
    assign s2_q  = req_q[OP_W-1:0];

    mixmul_core #(.OP_W(OP_W), .EXT_W(EXT_W)) u_core (
        .clk(clk),
        .rst(rst),
        .s1 (s1_q),
        .s2 (s2_q),
        .acc(acc_c)
    );

    mixmul_flags #(.OP_W(OP_W), .EXT_W(EXT_W)) u_flags (
        .clk  (clk),
        .rst  (rst),
        .acc  (acc_c),
        .dst  (dst_q),
        .word (word_c),
        .flags(flags_c)
    );

    assign res_d = {acc_c, word_c, flags_c};

    mixmul_stage #(.W(OUT_W)) u_out_stage (
        .clk (clk),
        .rst (rst),
        .vin (req_v),
        .din (res_d),
        .vout(out_valid),
        .dout(res_q)
    );

    assign out_acc   = res_q[OUT_W-1 -: ACC_W];
    assign out_word  = res_q[CCR_W +: OP_W];
    assign out_flags = res_q[CCR_W-1:0];

    ccr_t seen;
    assign seen = ccr_t'(out_flags);

    // R6
    zero_word_chk: assert property (@(posedge clk) disable iff (rst)
        seen.zero |-> (out_word == '0));

    // R8
    unnorm_word_chk: assert property (@(posedge clk) disable iff (rst)
        seen.unn |-> (out_word[OP_W-1] == out_word[OP_W-2]));

endmodule

// File: tb/mixmul_unit_tb.sv
`timescale 1ns/1ps
module mixmul_unit_tb;

    localparam int unsigned IN_REG = 1;
    localparam int unsigned LAT    = 1 + IN_REG;
    localparam int unsigned NSEND  = 400;
    localparam int unsigned NDIR   = 12;
    localparam int unsigned NCYC   = NSEND + LAT + 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] in_s1 = '0;
    logic [15:0] in_s2 = '0;
    logic        in_dst = 1'b0;
    logic        out_valid;
    logic [35:0] out_acc;
    logic [15:0] out_word;
    logic [5:0]  out_flags;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  finished = 1'b0;

    bit          exp_v  [NCYC];
    logic [35:0] exp_a  [NCYC];
    bit          exp_d  [NCYC];
    bit          exp_dir[NCYC];

    logic [35:0] last_acc   = '0;
    logic [15:0] last_word  = '0;
    logic [5:0]  last_flags = '0;

    always #10 clk = ~clk;

    mixmul_unit #(.IN_REG(IN_REG)) u_dut (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_s1    (in_s1),
        .in_s2    (in_s2),
        .in_dst   (in_dst),
        .out_valid(out_valid),
        .out_acc  (out_acc),
        .out_word (out_word),
        .out_flags(out_flags)
    );

    function automatic logic [35:0] ref_acc(input logic [15:0] a, input logic [15:0] b);
        longint p;
        p = longint'($signed(a)) * longint'(b) * 2;
        return p[35:0];
    endfunction

    function automatic logic [5:0] ref_flags(input logic [35:0] v, input bit to_word);
        logic [15:0] w;
        logic        used;
        logic        un;
        w    = v[31:16];
        used = !(v[35:31] == 5'b00000 || v[35:31] == 5'b11111);
        un   = (v[31] == v[30]);
        if (to_word) return {used, 1'b0, un, w[15], (w == 16'h0), used};
        return {1'b0, used, un, v[35], (v == 36'h0), 1'b0};
    endfunction

    function automatic logic [32:0] directed(input int i);
        case (i)
            0:  return {1'b0, 16'hFFF4, 16'h0002};
            1:  return {1'b1, 16'hFFF4, 16'h0002};
            2:  return {1'b0, 16'h8000, 16'hFFFF};
            3:  return {1'b1, 16'h8000, 16'hFFFF};
            4:  return {1'b0, 16'h0000, 16'hFFFF};
            5:  return {1'b1, 16'h8000, 16'h0000};
            6:  return {1'b0, 16'hFFFF, 16'hFFFF};
            7:  return {1'b0, 16'h7FFF, 16'hFFFF};
            8:  return {1'b1, 16'h7FFF, 16'hFFFF};
            9:  return {1'b1, 16'h0001, 16'h8000};
            10: return {1'b0, 16'hFFFF, 16'h0002};
            default: return {1'b0, 16'h0002, 16'hFFF4};
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd24681));
        repeat (3) @(negedge clk);
        // R10: state during reset
        chk(out_valid == 1'b0, "R10 valid in reset", 64'(out_valid), 64'h0);
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R10 valid", 64'(out_valid), 64'h0);
        chk(out_acc == '0, "R10 acc", 64'(out_acc), 64'h0);
        chk(out_word == '0, "R10 word", 64'(out_word), 64'h0);
        chk(out_flags == '0, "R10 flags", 64'(out_flags), 64'h0);

        for (int k = 0; k < NCYC; k++) begin
            @(negedge clk);
            // sample results for the request driven LAT cycles earlier
            if (k >= LAT && exp_v[k-LAT]) begin
                logic [35:0] ea;
                logic [5:0]  ef;
                bit          dw;
                ea = exp_a[k-LAT];
                dw = exp_d[k-LAT];
                ef = ref_flags(ea, dw);
                chk(out_valid == 1'b1, "R4 valid pulse", 64'(out_valid), 64'h1);
                chk(out_acc == ea, (k == LAT) ? "R2 example" : "R1 product",
                    64'(out_acc), 64'(ea));
                chk(out_word == ea[31:16], "R3 upper word", 64'(out_word), 64'(ea[31:16]));
                chk(out_flags == ef, dw ? "R9 word flags" : "R6 acc flags",
                    64'(out_flags), 64'(ef));
                chk(out_flags[3] == ef[3], "R8 unnormalized", 64'(out_flags[3]), 64'(ef[3]));
                if (!dw) begin
                    chk({out_flags[5], out_flags[4], out_flags[0]} == {ef[5], ef[4], ef[0]},
                        "R7 acc E/V/L", 64'(out_flags), 64'(ef));
                end
                if (exp_dir[k-LAT] && k == LAT + 3) begin
                    // R3: 0x8000 x 0xFFFF to a word, truncated not clamped
                    chk(out_word == 16'h0001, "R3 truncation", 64'(out_word), 64'h0001);
                end
                last_acc   = ea;
                last_word  = ea[31:16];
                last_flags = ef;
            end else begin
                chk(out_valid == 1'b0, "R4 idle", 64'(out_valid), 64'h0);
                chk(out_acc == last_acc, "R5 acc hold", 64'(out_acc), 64'(last_acc));
                chk(out_word == last_word, "R5 word hold", 64'(out_word), 64'(last_word));
                chk(out_flags == last_flags, "R5 flag hold", 64'(out_flags), 64'(last_flags));
            end

            // drive the next request
            exp_v[k]   = 1'b0;
            exp_dir[k] = 1'b0;
            if (k < NSEND) begin
                logic [32:0] op;
                bit          v;
                if (k < NDIR) begin
                    op = directed(k);
                    v  = 1'b1;
                    exp_dir[k] = 1'b1;
                end else begin
                    op = {1'($urandom), 16'($urandom), 16'($urandom)};
                    case ($urandom % 8)
                        0: op[31:16] = 16'h8000;
                        1: op[15:0]  = 16'hFFFF;
                        2: op[15:0]  = 16'h0000;
                        default: ;
                    endcase
                    v = ($urandom % 4) != 0;
                end
                in_valid = v;
                in_dst   = op[32];
                in_s1    = op[31:16];
                in_s2    = op[15:0];
                exp_v[k] = v;
                exp_d[k] = op[32];
                exp_a[k] = ref_acc(op[31:16], op[15:0]);
            end else begin
                in_valid = 1'b0;
                in_s1    = 16'h5A5A;
                in_s2    = 16'hA5A5;
            end
        end

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule